// File: doc/BRIEF.md
# Test Access Port with Internal-Scan Join

This block is a five-pin test access port controller. A sixteen-state controller, stepped by the test clock and the mode-select pin, walks the instruction and data shift paths. A 3-bit instruction register selects one of three data paths: a one-bit bypass flop, a parameterised boundary register that sits between the core and the pad logic, or a joined path. The joined path runs through the chip's internal scan chain and then through the boundary register. In the joined mode, data entering at the serial input passes first through the internal chain. The chain's serial output then feeds the boundary register, and the boundary register's last cell drives the serial output. The internal chain is therefore reachable through the test port alone, so no separate scan pins are needed for burn-in or diagnostics.

The internal chain lies outside the block. The block drives the chain's serial input and its scan enable, reads the chain's serial output, and issues a one-cycle functional capture strobe. The boundary register captures pad values, shifts them, and holds them in update latches that drive the pads only under the external-test instruction.

Controller states: Reset, Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR. The mode-select value sampled at each rising edge picks the next state (0 / 1):
- Reset goes to Idle / Reset.
- Idle goes to Idle / Select-DR.
- Select-DR goes to Capture-DR / Select-IR.
- Select-IR goes to Capture-IR / Reset.
- Capture-xR goes to Shift-xR / Exit1-xR.
- Shift-xR goes to Shift-xR / Exit1-xR.
- Exit1-xR goes to Pause-xR / Update-xR.
- Pause-xR goes to Pause-xR / Exit2-xR.
- Exit2-xR goes to Shift-xR / Update-xR.
- Update-xR goes to Idle / Select-DR.

Top module: `stt_tap`

## Requirements
- R1: Driving test_rst_n low asynchronously forces the Reset state. It also loads the bypass instruction, clears the boundary capture cells and update latches, and deasserts test_dout_en and pad_drive.
- R2: Holding test_mode_sel high for five rising edges of test_clk reaches the Reset state from any state, and the instruction register then holds the bypass instruction.
- R3: The controller follows the sixteen-state diagram above on rising test_clk edges. capture_dr is high exactly in Capture-DR and update_dr exactly in Update-DR.
- R4: The instruction register is 3 bits wide and shifts least significant bit first. In Capture-IR it loads 001, so the first three bits shifted out are 1, 0, 0. It takes the shifted value on the falling edge in Update-IR. The opcodes are: 000 external test, 001 sample, 010 preload, 011 joined scan, 111 bypass.
- R5: Opcode 111 and the undefined codes 100, 101 and 110 select the one-bit bypass flop. This flop captures 0, so a shift returns 0 followed by the input bits delayed by one.
- R6: test_dout changes only on falling test_clk edges. test_dout_en is high only while the controller is in Shift-DR or Shift-IR.
- R7: Under sample, the boundary register captures pad_in in Capture-DR and shifts out cell 0 first. Serial input enters cell BSR_LEN-1. Update-DR leaves pad_out unchanged.
- R8: Under preload, Capture-DR leaves the boundary register contents in place. Update-DR copies the register into pad_out on the falling edge, and pad_drive stays low.
- R9: Under external test, the boundary register captures pad_in, shifts, and is copied into pad_out in Update-DR. pad_drive is high only while this instruction is loaded.
- R10: Under joined scan, scan_si follows test_din, scan_so feeds boundary cell BSR_LEN-1, and cell 0 drives test_dout, giving one path of chain length plus BSR_LEN bits. scan_en is high only in Shift-DR under this instruction.
- R11: Under joined scan, Capture-DR raises scan_capture for one cycle while the boundary register captures pad_in. The first BSR_LEN bits out are therefore pad values and the rest are the chain's captured contents.
- R12: Under joined scan, Update-DR leaves pad_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_rst_n | input | 1 | Asynchronous active-low test reset |
| test_clk | input | 1 | Test clock |
| test_mode_sel | input | 1 | Mode select sampled on rising edges |
| test_din | input | 1 | Serial test data in |
| test_dout | output | 1 | Serial test data out, updated on falling edges |
| test_dout_en | output | 1 | Output enable for test_dout |
| pad_in | input | BSR_LEN | Values seen at the pads, captured by boundary cells |
| pad_out | output | BSR_LEN | Boundary update latches toward the pads |
| pad_drive | output | 1 | Pads take pad_out when high |
| scan_si | output | 1 | Serial input to the internal scan chain |
| scan_so | input | 1 | Serial output of the internal scan chain |
| scan_en | output | 1 | Internal chain shift enable |
| scan_capture | output | 1 | Internal chain functional capture strobe |
| capture_dr | output | 1 | High in Capture-DR |
| update_dr | output | 1 | High in Update-DR |

## Verification
A corrupted controller state shows at the ports within one test clock. The capture and update strobes, or test_dout_en, appear in the wrong cycle, and test_dout shifts out a path of the wrong length. A wrong instruction register value shows up in the next data shift as a wrong path length or wrong first bits, and pad_drive changes on the next falling edge. A fault in the joined path or in a boundary cell shows as a misplaced bit in the shifted-out stream within one shift sequence. A later preload shift exposes what was left behind in the boundary register.

// File: rtl/stt_tap_pkg.sv
package stt_tap_pkg;

    typedef enum logic [3:0] {
        TAP_RESET,
        TAP_IDLE,
        TAP_SEL_DR,
        TAP_CAP_DR,
        TAP_SHF_DR,
        TAP_EX1_DR,
        TAP_PAU_DR,
        TAP_EX2_DR,
        TAP_UPD_DR,
        TAP_SEL_IR,
        TAP_CAP_IR,
        TAP_SHF_IR,
        TAP_EX1_IR,
        TAP_PAU_IR,
        TAP_EX2_IR,
        TAP_UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = 3'b000;
    localparam opcode_t OP_SAMPLE  = 3'b001;
    localparam opcode_t OP_PRELOAD = 3'b010;
    localparam opcode_t OP_JOIN    = 3'b011;
    localparam opcode_t OP_BYPASS  = 3'b111;
    localparam opcode_t IR_CAPTURE = 3'b001;

    // Per-instruction data path selection
    typedef struct packed {
        logic use_bsr;    // boundary register in the path
        logic use_chain;  // internal chain ahead of the boundary register
        logic cap_pads;   // boundary cells load pad_in in Capture-DR
        logic upd_pads;   // update latches load in Update-DR
        logic drive;      // pads follow the update latches
    } dr_sel_t;

endpackage

// File: rtl/stt_tap_fsm.sv
module stt_tap_fsm
    import stt_tap_pkg::*;
(
    input  logic       test_clk,
    input  logic       test_rst_n,
    input  logic       mode_sel,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir
);

    tap_state_e nxt;

    // State register
    always_ff @(posedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n) state <= TAP_RESET;
        else             state <= nxt;
    end

    // Transition table
    always_comb begin
        nxt = state;
        unique case (state)
            TAP_RESET:  nxt = mode_sel ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   nxt = mode_sel ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: nxt = mode_sel ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: nxt = mode_sel ? TAP_EX1_DR : TAP_SHF_DR;
            TAP_SHF_DR: nxt = mode_sel ? TAP_EX1_DR : TAP_SHF_DR;
            TAP_EX1_DR: nxt = mode_sel ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: nxt = mode_sel ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: nxt = mode_sel ? TAP_UPD_DR : TAP_SHF_DR;
            TAP_UPD_DR: nxt = mode_sel ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: nxt = mode_sel ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: nxt = mode_sel ? TAP_EX1_IR : TAP_SHF_IR;
            TAP_SHF_IR: nxt = mode_sel ? TAP_EX1_IR : TAP_SHF_IR;
            TAP_EX1_IR: nxt = mode_sel ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: nxt = mode_sel ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: nxt = mode_sel ? TAP_UPD_IR : TAP_SHF_IR;
            TAP_UPD_IR: nxt = mode_sel ? TAP_SEL_DR : TAP_IDLE;
            default:    nxt = TAP_RESET;
        endcase
    end

    // Output decode
    always_comb begin
        in_reset = (state == TAP_RESET);
        cap_dr   = (state == TAP_CAP_DR);
        shf_dr   = (state == TAP_SHF_DR);
        upd_dr   = (state == TAP_UPD_DR);
        cap_ir   = (state == TAP_CAP_IR);
        shf_ir   = (state == TAP_SHF_IR);
        upd_ir   = (state == TAP_UPD_IR);
    end

    // R2: five rising edges with mode_sel high land in Reset
    a_r2_five_high_reset: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (mode_sel && $past(mode_sel, 1) && $past(mode_sel, 2) && $past(mode_sel, 3)
         && $past(mode_sel, 4)) |=> (state == TAP_RESET));

    // R3: leaving Reset with mode_sel low enters Idle
    a_r3_reset_to_idle: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (state == TAP_RESET && !mode_sel) |=> (state == TAP_IDLE));

    // R3: a shift state is only reached from capture, shift or exit2 of the same side
    a_r3_shift_dr_entry: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (state == TAP_SHF_DR && $past(state) != TAP_SHF_DR) |->
            ($past(state) == TAP_CAP_DR || $past(state) == TAP_EX2_DR));

endmodule

// File: rtl/stt_tap_ir.sv
module stt_tap_ir
    import stt_tap_pkg::*;
(
    input  logic    test_clk,
    input  logic    test_rst_n,
    input  logic    ser_in,
    input  logic    in_reset,
    input  logic    cap_ir,
    input  logic    shf_ir,
    input  logic    upd_ir,
    output opcode_t opcode,
    output logic    ser_out
);

    opcode_t sh_q;

    // Shift stage: capture fixed pattern, shift LSB first
    always_ff @(posedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n)  sh_q <= IR_CAPTURE;
        else if (cap_ir)  sh_q <= IR_CAPTURE;
        else if (shf_ir)  sh_q <= {ser_in, sh_q[IR_W-1:1]};
    end

    // Holding stage: loads on the falling edge
    always_ff @(negedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n)   opcode <= OP_BYPASS;
        else if (in_reset) opcode <= OP_BYPASS;
        else if (upd_ir)   opcode <= sh_q;
    end

    assign ser_out = sh_q[0];

    // R2: while in Reset the held instruction is bypass
    a_r2_reset_holds_bypass: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        in_reset |-> (opcode == OP_BYPASS));

    // R4: the held instruction moves only through Update-IR or Reset
    a_r4_opcode_changes_on_update: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        !$stable(opcode) |-> (upd_ir || in_reset));

endmodule

// File: rtl/stt_tap_bsr.sv
module stt_tap_bsr #(
    parameter int BSR_LEN = 151
) (
    input  logic               test_clk,
    input  logic               test_rst_n,
    input  logic               ser_in,
    input  logic               capture,
    input  logic               shift,
    input  logic               update,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic [BSR_LEN-1:0] pad_out,
    output logic               ser_out
);

    // link[i] is the output of cell i; link[BSR_LEN] is the serial input
    logic [BSR_LEN:0] link;
    assign link[BSR_LEN] = ser_in;

    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        logic cap_q;
        logic upd_q;

        always_ff @(posedge test_clk or negedge test_rst_n) begin
            if (!test_rst_n)   cap_q <= 1'b0;
            else if (capture)  cap_q <= pad_in[i];
            else if (shift)    cap_q <= link[i+1];
        end

        always_ff @(negedge test_clk or negedge test_rst_n) begin
            if (!test_rst_n)   upd_q <= 1'b0;
            else if (update)   upd_q <= cap_q;
        end

        assign link[i]    = cap_q;
        assign pad_out[i] = upd_q;
    end

    assign ser_out = link[0];

    // R12: update latches move only on an enabled update
    a_r12_pads_change_only_on_update: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        !$stable(pad_out) |-> update);

    // R7: capture and shift never requested together
    a_r7_capture_shift_exclusive: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        !(capture && shift));

endmodule

// File: rtl/stt_tap.sv
module stt_tap
    import stt_tap_pkg::*;
#(
    parameter int BSR_LEN = 151
) (
    input  logic               test_rst_n,
    input  logic               test_clk,
    input  logic               test_mode_sel,
    input  logic               test_din,
    output logic               test_dout,
    output logic               test_dout_en,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic [BSR_LEN-1:0] pad_out,
    output logic               pad_drive,
    output logic               scan_si,
    input  logic               scan_so,
    output logic               scan_en,
    output logic               scan_capture,
    output logic               capture_dr,
    output logic               update_dr
);

    tap_state_e state;
    logic       in_reset, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;
    opcode_t    opcode;
    logic       ir_so;
    dr_sel_t    sel;
    logic       byp_q;
    logic       bsr_si, bsr_so, dr_so, out_next;
    logic       dout_q, dout_en_q;

    stt_tap_fsm i_fsm (
        .test_clk   (test_clk),
        .test_rst_n (test_rst_n),
        .mode_sel   (test_mode_sel),
        .state      (state),
        .in_reset   (in_reset),
        .cap_dr     (cap_dr),
        .shf_dr     (shf_dr),
        .upd_dr     (upd_dr),
        .cap_ir     (cap_ir),
        .shf_ir     (shf_ir),
        .upd_ir     (upd_ir)
    );

    stt_tap_ir i_ir (
        .test_clk   (test_clk),
        .test_rst_n (test_rst_n),
        .ser_in     (test_din),
        .in_reset   (in_reset),
        .cap_ir     (cap_ir),
        .shf_ir     (shf_ir),
        .upd_ir     (upd_ir),
        .opcode     (opcode),
        .ser_out    (ir_so)
    );

    // Instruction decode; anything unlisted falls to bypass
    always_comb begin
        sel = '0;
        unique case (opcode)
            OP_EXTEST: begin
                sel.use_bsr  = 1'b1;
                sel.cap_pads = 1'b1;
                sel.upd_pads = 1'b1;
                sel.drive    = 1'b1;
            end
            OP_SAMPLE: begin
                sel.use_bsr  = 1'b1;
                sel.cap_pads = 1'b1;
            end
            OP_PRELOAD: begin
                sel.use_bsr  = 1'b1;
                sel.upd_pads = 1'b1;
            end
            OP_JOIN: begin
                sel.use_bsr   = 1'b1;
                sel.use_chain = 1'b1;
                sel.cap_pads  = 1'b1;
            end
            default: sel = '0;
        endcase
    end

    // Joined path: test_din -> chain -> boundary register -> test_dout
    assign scan_si      = test_din;
    assign bsr_si       = sel.use_chain ? scan_so : test_din;
    assign scan_en      = shf_dr & sel.use_chain;
    assign scan_capture = cap_dr & sel.use_chain;

    stt_tap_bsr #(.BSR_LEN(BSR_LEN)) i_bsr (
        .test_clk   (test_clk),
        .test_rst_n (test_rst_n),
        .ser_in     (bsr_si),
        .capture    (cap_dr & sel.cap_pads),
        .shift      (shf_dr & sel.use_bsr),
        .update     (upd_dr & sel.upd_pads),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .ser_out    (bsr_so)
    );

    // Bypass flop
    always_ff @(posedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n)                 byp_q <= 1'b0;
        else if (cap_dr && !sel.use_bsr) byp_q <= 1'b0;
        else if (shf_dr && !sel.use_bsr) byp_q <= test_din;
    end

    assign dr_so    = sel.use_bsr ? bsr_so : byp_q;
    assign out_next = shf_ir ? ir_so : dr_so;

    // Serial output retimed to the falling edge
    always_ff @(negedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n) begin
            dout_q    <= 1'b0;
            dout_en_q <= 1'b0;
        end else begin
            dout_en_q <= shf_dr | shf_ir;
            if (shf_dr || shf_ir) dout_q <= out_next;
        end
    end

    assign test_dout    = dout_q;
    assign test_dout_en = dout_en_q;
    assign pad_drive    = sel.drive;
    assign capture_dr   = cap_dr;
    assign update_dr    = upd_dr;

    // R6: output enabled only inside a shift state
    a_r6_dout_en_in_shift: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        test_dout_en |-> (state == TAP_SHF_DR || state == TAP_SHF_IR));

    // R5: bypass flop holds 0 right after a bypass capture
    a_r5_bypass_captures_zero: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (cap_dr && !sel.use_bsr) |=> (byp_q == 1'b0));

    // R10: scan enable rises only on entry into Shift-DR
    a_r10_scan_en_entry: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        $rose(scan_en) |-> ($past(state) == TAP_CAP_DR || $past(state) == TAP_EX2_DR));

    // R11: functional capture strobe lasts one cycle
    a_r11_capture_single_cycle: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        scan_capture |=> !scan_capture);

endmodule

// File: tb/test_stt_tap.sv
module test_stt_tap;

    localparam int CLK_PERIOD = 10;
    localparam int BSR_N      = 12;
    localparam int CHAIN_N    = 20;

    localparam logic [2:0] C_EXTEST  = 3'b000;
    localparam logic [2:0] C_SAMPLE  = 3'b001;
    localparam logic [2:0] C_PRELOAD = 3'b010;
    localparam logic [2:0] C_JOIN    = 3'b011;
    localparam logic [2:0] C_BYPASS  = 3'b111;

    logic               test_clk = 1'b0;
    logic               test_rst_n;
    logic               test_mode_sel;
    logic               test_din;
    logic               test_dout, test_dout_en;
    logic [BSR_N-1:0]   pad_in;
    logic [BSR_N-1:0]   pad_out;
    logic               pad_drive;
    logic               scan_si, scan_so, scan_en, scan_capture;
    logic               capture_dr, update_dr;

    // Bench model of the internal scan chain
    logic [CHAIN_N-1:0] chain = '0;
    logic [CHAIN_N-1:0] func_word = '0;

    int errors = 0;
    int checks = 0;
    int rise_bad = 0;
    bit done = 1'b0;

    logic [BSR_N-1:0]   bsr_m;
    logic [BSR_N-1:0]   pad_m;

    always #(CLK_PERIOD/2) test_clk = ~test_clk;

    always @(posedge test_clk) begin
        if (scan_capture)  chain <= func_word;
        else if (scan_en)  chain <= {scan_si, chain[CHAIN_N-1:1]};
    end
    assign scan_so = chain[0];

    stt_tap #(.BSR_LEN(BSR_N)) i_stt_tap (
        .test_rst_n    (test_rst_n),
        .test_clk      (test_clk),
        .test_mode_sel (test_mode_sel),
        .test_din      (test_din),
        .test_dout     (test_dout),
        .test_dout_en  (test_dout_en),
        .pad_in        (pad_in),
        .pad_out       (pad_out),
        .pad_drive     (pad_drive),
        .scan_si       (scan_si),
        .scan_so       (scan_so),
        .scan_en       (scan_en),
        .scan_capture  (scan_capture),
        .capture_dr    (capture_dr),
        .update_dr     (update_dr)
    );

    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    // Called just after a falling edge; returns test_dout as seen before the rising edge
    task automatic tick(input logic ms, input logic di, output logic o);
        test_mode_sel = ms;
        test_din      = di;
        #1;
        o = test_dout;
        @(posedge test_clk);
        #1;
        if (test_dout !== o) rise_bad++;
        @(negedge test_clk);
        #1;
    endtask

    task automatic load_ir(input logic [2:0] op);
        logic       o;
        logic [2:0] cap;
        tick(1'b1, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, op[i], o);
            cap[i] = o;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        check("R4 instruction capture pattern", 64'(cap), 64'(3'b001));
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            C_EXTEST:  return "R9 external test";
            C_SAMPLE:  return "R7 sample";
            C_PRELOAD: return "R8 preload";
            C_JOIN:    return "R10 R11 joined scan";
            default:   return "R5 bypass";
        endcase
    endfunction

    // One data-register pass from Idle back to Idle, checked against the bench model
    task automatic run_op(input logic [2:0] op, input bit do_load, input string tag);
        logic [63:0]        din, dout, expo, mask;
        logic [BSR_N-1:0]   cap_b;
        logic [CHAIN_N-1:0] chain_before;
        logic               o;
        bit                 is_join, is_bsr, caps, upds;
        int                 n;
        is_join = (op == C_JOIN);
        is_bsr  = (op == C_EXTEST) || (op == C_SAMPLE) || (op == C_PRELOAD) || is_join;
        caps    = (op == C_EXTEST) || (op == C_SAMPLE) || is_join;
        upds    = (op == C_EXTEST) || (op == C_PRELOAD);
        n       = is_join ? (BSR_N + CHAIN_N) : (is_bsr ? BSR_N : 6);
        if (do_load) load_ir(op);
        check({tag, " R9 pad_drive"}, 64'(pad_drive), 64'(op == C_EXTEST));

        pad_in    = BSR_N'($urandom());
        func_word = CHAIN_N'($urandom());
        din       = {$urandom(), $urandom()};
        chain_before = chain;
        cap_b = caps ? pad_in : bsr_m;
        if (is_join)     expo = 64'({func_word, cap_b});
        else if (is_bsr) expo = 64'(cap_b);
        else             expo = {din[62:0], 1'b0};

        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        check({tag, " R3 capture_dr strobe"}, 64'(capture_dr), 64'd1);
        check({tag, " R11 scan_capture strobe"}, 64'(scan_capture), 64'(is_join));
        tick(1'b0, 1'b0, o);
        check({tag, " R6 dout_en in shift"}, 64'(test_dout_en), 64'd1);
        check({tag, " R10 scan_en in shift"}, 64'(scan_en), 64'(is_join));
        dout = '0;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
        end
        tick(1'b1, 1'b0, o);
        check({tag, " R3 update_dr strobe"}, 64'(update_dr), 64'd1);
        check({tag, " R6 dout_en off"}, 64'(test_dout_en), 64'd0);
        tick(1'b0, 1'b0, o);

        mask = (64'd1 << n) - 64'd1;
        check({tag, " shifted-out stream"}, dout, expo & mask);
        if (is_bsr) bsr_m = din[BSR_N-1:0];
        if (upds)   pad_m = bsr_m;
        check({tag, is_join ? " R12 pad_out" : " pad_out"}, 64'(pad_out), 64'(pad_m));
        check({tag, " R10 chain contents"}, 64'(chain),
              64'(is_join ? din[BSR_N+CHAIN_N-1:BSR_N] : chain_before));
        check({tag, " R6 no change on rising edge"}, 64'(rise_bad), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic o;
        void'($urandom(32'd917));
        test_rst_n    = 1'b0;
        test_mode_sel = 1'b1;
        test_din      = 1'b0;
        pad_in        = '0;
        repeat (3) @(negedge test_clk);
        #1;
        check("R1 reset dout_en",   64'(test_dout_en), 64'd0);
        check("R1 reset pad_out",   64'(pad_out),      64'd0);
        check("R1 reset pad_drive", 64'(pad_drive),    64'd0);
        check("R1 reset capture_dr", 64'(capture_dr),  64'd0);
        test_rst_n = 1'b1;
        bsr_m = '0;
        pad_m = '0;
        tick(1'b0, 1'b0, o);

        // Bypass without any instruction load proves the reset instruction
        run_op(C_BYPASS, 1'b0, "R1 R5 reset instruction");
        run_op(C_SAMPLE,  1'b1, "R7 sample");
        run_op(C_PRELOAD, 1'b1, "R8 preload");
        run_op(C_EXTEST,  1'b1, "R9 external test");
        run_op(C_JOIN,    1'b1, "R10 R11 joined scan");
        run_op(C_PRELOAD, 1'b1, "R10 leftover after joined scan");
        for (int k = 4; k < 7; k++) run_op(3'(k), 1'b1, "R5 undefined opcode");

        // Five high mode_sel edges from Idle
        load_ir(C_EXTEST);
        check("R9 drive under external test", 64'(pad_drive), 64'd1);
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o);
        check("R2 five-high reset drops drive", 64'(pad_drive), 64'd0);
        tick(1'b0, 1'b0, o);
        run_op(C_BYPASS, 1'b0, "R2 bypass after five-high reset");

        // Asynchronous reset in the middle of operation
        load_ir(C_EXTEST);
        #2;
        test_rst_n = 1'b0;
        #1;
        check("R1 async reset pad_out",   64'(pad_out),   64'd0);
        check("R1 async reset pad_drive", 64'(pad_drive), 64'd0);
        @(negedge test_clk);
        #1;
        test_rst_n = 1'b1;
        bsr_m = '0;
        pad_m = '0;
        tick(1'b0, 1'b0, o);
        run_op(C_PRELOAD, 1'b1, "R1 cleared boundary cells");

        // Random mix of instructions
        for (int k = 0; k < 40; k++) begin
            logic [2:0] op;
            op = 3'($urandom() % 8);
            run_op(op, 1'b1, tag_of(op));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule